// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block serves the transmit side of a network DMA engine. Software arranges a ring of 32-byte descriptors in memory, hands descriptors to the hardware by setting their ownership flag, and then pulses a poll-demand input. The walker then reads descriptors from its current pointer onward. For each owned descriptor it checks the buffer sizes, fetches the buffer through a word-wide memory port, and streams the bytes out one per cycle. It then hands the descriptor back to software and moves on. The walk ends at the first descriptor that software still owns, or silently at the first malformed one.

A descriptor's word 0 is the control word. Word 1 holds two size fields and word 2 holds the buffer address. The remaining words are neither read nor written. A write of the base-address input loads both the ring base and the current pointer. When a descriptor carries the end-of-ring flag, the pointer returns to that base.

Top module: `txd_ring_walker`

## Requirements
- R1: A poll-demand pulse starts a walk at the current pointer by reading the control word (offset 0). If bit 31 (ownership) of that word is clear, the walk ends with no write and no output.
- R2: The buffer length is bits 11:0 of word 1. The buffer byte address is word 2 with its two low bits ignored. Bytes leave little-endian (bits 7:0 of a word first), one per valid cycle, and exactly the buffer length is emitted; the surplus bytes of the final word are dropped.
- R3: If the buffer length exceeds MAX_BUF (2048), or bits 27:16 of word 1 (second buffer length) are nonzero, the walk stops. No byte is emitted and nothing is written back. A length of exactly 2048 is accepted.
- R4: If the bytes accepted so far in the current frame plus the new length would reach FRAME_LIM (8192), the walk stops without write-back. The running total restarts at each walk start and after each last buffer.
- R5: Bit 29 of the control word marks a frame's last buffer. Its final byte carries tx_last, and frame_done pulses for one cycle in the cycle after that descriptor's write-back is accepted.
- R6: After each accepted buffer, exactly one write puts the control word back to the descriptor's address, with bit 31 cleared and every other bit unchanged.
- R7: After write-back, the pointer reloads from the ring base if control bit 21 is set; otherwise it advances by 32 bytes. A base write sets both the base and the pointer.
- R8: A poll demand that arrives during a walk is held and starts a new walk once the current one ends.
- R9: After reset the block is idle: no memory request, no valid byte, no frame_done.
- R10: A memory request keeps its address, write flag and data until mem_ack; every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll | input | 1 | Poll-demand pulse |
| base_we | input | 1 | Load ring base and current pointer |
| base_addr | input | AW | Ring base byte address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| frame_done | output | 1 | Transmit-complete and normal-summary status pulse |

## Verification
Some properties hold on every cycle and are checked by the assertions. These cover the idle state after reset, held and aligned memory requests, and write-backs that always clear ownership and never come back to back. They also cover tx_last appearing only with a valid byte, and frame_done being a single-cycle pulse that follows an accepted write.

Other behaviour depends on descriptor contents and is shown only by the bench's scenarios. That includes:
- the byte contents and count;
- rejection at 2049 bytes versus acceptance at 2048;
- the 8192-byte frame cut-off;
- wrap to the base instead of advancing;
- a second walk from a poll held during a busy walk.

The memory model withholds mem_ack every other cycle, so request holding is also exercised.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CTL, S_SIZE, S_BADDR, S_CHECK, S_DATA, S_SHIFT, S_WBACK
  } walk_st_t;

  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 29;
  localparam int WRAP_BIT  = 21;
  localparam int BUF2_LSB  = 16;
  localparam int OFS_SIZE  = 4;
  localparam int OFS_BADDR = 8;
  localparam int DESC_BYTES = 32;
endpackage

// File: rtl/txd_len_check.sv
module txd_len_check #(
  parameter int LENW      = 12,
  parameter int MAX_BUF   = 2048,
  parameter int FRAME_LIM = 8192,
  localparam int ACCW     = $clog2(FRAME_LIM) + 1
) (
  input  logic [LENW-1:0] len1,
  input  logic [LENW-1:0] len2,
  input  logic [ACCW-1:0] acc,
  output logic            reject
);
  logic [ACCW:0] sum;
  logic          too_big, second_used, over_lim;

  always_comb begin
    sum         = {1'b0, acc} + (ACCW+1)'(len1);
    too_big     = {1'b0, len1} > (LENW+1)'(MAX_BUF);
    second_used = len2 != '0;
    over_lim    = sum >= (ACCW+1)'(FRAME_LIM);
    reject      = too_big | second_used | over_lim;
  end
endmodule

// File: rtl/txd_ptr.sv
module txd_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic [AW-1:0] base_din,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur    <= '0;
    end else if (base_we) begin
      base_q <= base_din;
      cur    <= base_din;
    end else if (adv) begin
      cur <= wrap ? base_q : cur + AW'(STEP);
    end
  end
endmodule

// File: rtl/txd_byte_ser.sv
module txd_byte_ser #(
  parameter int DW = 32,
  localparam int NB  = DW / 8,
  localparam int CW  = $clog2(NB) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] word,
  input  logic [CW-1:0] nbytes,
  input  logic          mark,
  output logic          busy,
  output logic          o_valid,
  output logic [7:0]    o_data,
  output logic          o_last
);
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          mk;

  assign busy = cnt != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      mk      <= 1'b0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_last  <= 1'b0;
    end else if (load) begin
      sh      <= word;
      cnt     <= nbytes;
      mk      <= mark;
      o_valid <= 1'b0;
      o_last  <= 1'b0;
    end else if (cnt != '0) begin
      o_valid <= 1'b1;
      o_data  <= sh[7:0];
      o_last  <= mk && (cnt == CW'(1));
      sh      <= sh >> 8;
      cnt     <= cnt - CW'(1);
    end else begin
      o_valid <= 1'b0;
      o_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
  import txd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LENW      = 12,
  parameter int MAX_BUF   = 2048,
  parameter int FRAME_LIM = 8192,
  localparam int DW       = 32,
  localparam int NB       = DW / 8,
  localparam int CW       = $clog2(NB) + 1,
  localparam int ACCW     = $clog2(FRAME_LIM) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          poll,
  input  logic          base_we,
  input  logic [AW-1:0] base_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          frame_done
);
  walk_st_t        st;
  logic [31:0]     ctl_q;
  logic [LENW-1:0] len1_q, len2_q, rem;
  logic [AW-1:0]   bufp;
  logic [ACCW-1:0] acc;
  logic            pend, done_q;
  logic [AW-1:0]   cur;
  logic            reject, ser_busy, ser_load, adv;
  logic [CW-1:0]   nb;
  logic            mark;

  txd_len_check #(.LENW(LENW), .MAX_BUF(MAX_BUF), .FRAME_LIM(FRAME_LIM)) u_chk_len (
    .len1(len1_q), .len2(len2_q), .acc(acc), .reject(reject)
  );

  assign adv = (st == S_WBACK) && mem_ack;

  txd_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
    .clk(clk), .rst(rst), .base_we(base_we), .base_din(base_addr),
    .adv(adv), .wrap(ctl_q[WRAP_BIT]), .cur(cur)
  );

  always_comb begin
    nb       = (rem >= LENW'(NB)) ? CW'(NB) : CW'(rem);
    mark     = ctl_q[LAST_BIT] && (rem == LENW'(nb));
    ser_load = (st == S_DATA) && mem_ack;
  end

  txd_byte_ser #(.DW(DW)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .word(mem_rdata), .nbytes(nb),
    .mark(mark), .busy(ser_busy), .o_valid(tx_valid), .o_data(tx_data),
    .o_last(tx_last)
  );

  // Memory port decode from the registered state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    unique case (st)
      S_CTL:   mem_req = 1'b1;
      S_SIZE:  begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_SIZE); end
      S_BADDR: begin mem_req = 1'b1; mem_addr = cur + AW'(OFS_BADDR); end
      S_DATA:  begin mem_req = 1'b1; mem_addr = bufp; end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = ctl_q & ~(32'h1 << OWN_BIT);
      end
      default: ;
    endcase
  end

  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ctl_q  <= '0;
      len1_q <= '0;
      len2_q <= '0;
      rem    <= '0;
      bufp   <= '0;
      acc    <= '0;
      pend   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pend   <= poll | (pend & (st != S_IDLE));
      unique case (st)
        S_IDLE: if (pend) begin
          acc <= '0;
          st  <= S_CTL;
        end
        S_CTL: if (mem_ack) begin
          ctl_q <= mem_rdata;
          st    <= mem_rdata[OWN_BIT] ? S_SIZE : S_IDLE;
        end
        S_SIZE: if (mem_ack) begin
          len1_q <= mem_rdata[LENW-1:0];
          len2_q <= mem_rdata[BUF2_LSB +: LENW];
          st     <= S_BADDR;
        end
        S_BADDR: if (mem_ack) begin
          bufp <= {mem_rdata[AW-1:2], 2'b00};
          st   <= S_CHECK;
        end
        S_CHECK: begin
          rem <= len1_q;
          if (reject)              st <= S_IDLE;
          else if (len1_q == '0)   st <= S_WBACK;
          else                     st <= S_DATA;
        end
        S_DATA: if (mem_ack) begin
          rem  <= rem - LENW'(nb);
          bufp <= bufp + AW'(NB);
          st   <= S_SHIFT;
        end
        S_SHIFT: if (!ser_busy) begin
          st <= (rem == '0) ? S_WBACK : S_DATA;
        end
        S_WBACK: if (mem_ack) begin
          if (ctl_q[LAST_BIT]) begin
            acc    <= '0;
            done_q <= 1'b1;
          end else begin
            acc <= acc + ACCW'(len1_q);
          end
          st <= S_CTL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          tx_valid,
  input logic          tx_last,
  input logic          frame_done
);
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !tx_valid && !frame_done));

  p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_addr_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_wb_clears_own_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  p_wb_single_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> !(mem_req && mem_we));

  p_last_with_valid_r5: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_done_after_wb_r5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.AW(AW)) u_walker_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_valid(tx_valid), .tx_last(tx_last), .frame_done(frame_done)
);

// File: tb/tb_txd_ring_walker.sv
module tb_txd_ring_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] LAST = 32'h2000_0000;
  localparam logic [31:0] WRAP = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        poll = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_addr = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, frame_done;
  logic [7:0]  tx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_ring_walker dut (
    .clk(clk), .rst(rst), .poll(poll), .base_we(base_we), .base_addr(base_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .frame_done(frame_done)
  );

  // Memory model: 4 KB, ack withheld every other cycle (stalls exercise R10)
  logic [31:0] mem [0:1023];
  logic        gate = 1'b0;
  logic        hw_en = 1'b0;
  logic [31:0] hw_addr = '0, hw_data = '0;
  assign mem_ack   = mem_req & gate;
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    gate <= ~gate;
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else begin
      if (hw_en) mem[hw_addr[11:2]] <= hw_data;
      if (mem_ack && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end
  end

  // Output monitor
  int         byte_n = 0, done_n = 0, watch_n = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFF;
  logic [7:0] blog [0:16383];
  logic       llog [0:16383];
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid) begin
        blog[byte_n] = tx_data;
        llog[byte_n] = tx_last;
        byte_n++;
      end
      if (frame_done) done_n++;
      if (mem_req && mem_ack && !mem_we && mem_addr == watch_addr) watch_n++;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic mk_desc(input logic [31:0] a, input logic [31:0] ctl,
                         input logic [31:0] sz, input logic [31:0] ba);
    host_wr(a + 4, sz);
    host_wr(a + 8, ba);
    host_wr(a, ctl);
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_idle();
    int s = 0;
    while (s < 6) begin
      @(negedge clk);
      if (!mem_req && !tx_valid) s++; else s = 0;
    end
  endtask

  task automatic walk();
    pulse_poll();
    wait_idle();
  endtask

  // Compare a run of logged bytes with the pattern starting at buffer offset off
  task automatic cmp_bytes(input string req, input int from, input int n, input int off);
    int bad = 0;
    for (int i = 0; i < n; i++) if (blog[from + i] !== pat(off + i)) bad++;
    chk(req, "byte mismatches", bad, 0);
  endtask

  function automatic int count_last(input int from, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (llog[from + i]) c++;
    return c;
  endfunction

  task automatic t_reset();
    chk("R9", "mem_req after reset", mem_req, 0);
    chk("R9", "tx_valid after reset", tx_valid, 0);
    chk("R9", "frame_done after reset", frame_done, 0);
  endtask

  task automatic t_single();
    int b0 = byte_n, d0 = done_n;
    mk_desc(32'h100, OWN | LAST | 32'h55, 32'd6, 32'h801);
    walk();
    chk("R2", "byte count len 6", byte_n - b0, 6);
    cmp_bytes("R2/R10", b0, 6, 0);
    chk("R5", "tx_last on 6th byte", llog[b0 + 5], 1);
    chk("R5", "tx_last count", count_last(b0, 6), 1);
    chk("R5", "frame_done pulses", done_n - d0, 1);
    chk("R6", "written-back control word", mem[32'h100 >> 2], LAST | 32'h55);
  endtask

  task automatic t_multi();
    int b0 = byte_n, d0 = done_n;
    mk_desc(32'h120, OWN, 32'd5, 32'h804);
    mk_desc(32'h140, OWN | LAST, 32'd3, 32'h810);
    walk();
    chk("R1", "bytes from two buffers", byte_n - b0, 8);
    cmp_bytes("R2", b0, 5, 4);
    cmp_bytes("R2", b0 + 5, 3, 16);
    chk("R5", "only final byte has tx_last", count_last(b0, 7), 0);
    chk("R5", "final tx_last", llog[b0 + 7], 1);
    chk("R5", "one frame_done", done_n - d0, 1);
    chk("R6", "first buffer owned cleared", mem[32'h120 >> 2], 0);
  endtask

  task automatic t_wrap();
    int b0 = byte_n, d0 = done_n;
    mk_desc(32'h160, OWN | LAST | WRAP, 32'd4, 32'h800);
    mk_desc(32'h180, OWN | LAST, 32'd1, 32'h800);
    walk();
    chk("R7", "wrap descriptor bytes", byte_n - b0, 4);
    chk("R1", "base desc unowned ends walk", done_n - d0, 1);
    chk("R7", "descriptor after wrap untouched", mem[32'h180 >> 2], OWN | LAST);
    b0 = byte_n;
    mk_desc(32'h100, OWN | LAST, 32'd2, 32'h808);
    walk();
    chk("R7", "walk resumed at base", byte_n - b0, 2);
    cmp_bytes("R7", b0, 2, 8);
    chk("R7", "decoy still owned", mem[32'h180 >> 2], OWN | LAST);
    host_wr(32'h180, 32'h0);
  endtask

  task automatic t_reject();
    int b0 = byte_n, d0 = done_n;
    mk_desc(32'h120, OWN | LAST, 32'd2049, 32'h800);
    walk();
    chk("R3", "len 2049 emits nothing", byte_n - b0, 0);
    chk("R3", "len 2049 not written back", mem[32'h120 >> 2], OWN | LAST);
    host_wr(32'h124, 32'h0001_0004);
    walk();
    chk("R3", "second length nonzero emits nothing", byte_n - b0, 0);
    chk("R3", "second length not written back", mem[32'h120 >> 2], OWN | LAST);
    chk("R3", "no frame_done on rejects", done_n - d0, 0);
    host_wr(32'h124, 32'd2048);
    walk();
    chk("R3", "len 2048 accepted", byte_n - b0, 2048);
    cmp_bytes("R2", b0, 2048, 0);
    chk("R5", "last on byte 2048", llog[b0 + 2047], 1);
    chk("R6", "2048 buffer written back", mem[32'h120 >> 2], LAST);
  endtask

  task automatic t_limit();
    int b0 = byte_n, d0 = done_n;
    for (int k = 0; k < 4; k++) mk_desc(32'h140 + 32 * k, OWN, 32'd2048, 32'h800);
    walk();
    chk("R4", "three buffers then stop", byte_n - b0, 6144);
    chk("R4", "no tx_last without last flag", count_last(b0, 6144), 0);
    chk("R4", "no frame_done", done_n - d0, 0);
    chk("R4", "fourth descriptor still owned", mem[32'h1A0 >> 2], OWN);
    chk("R6", "third descriptor released", mem[32'h180 >> 2], 0);
    b0 = byte_n;
    mk_desc(32'h1A0, OWN | LAST, 32'd8, 32'h800);
    walk();
    chk("R4", "total restarts at new walk", byte_n - b0, 8);
    chk("R5", "frame_done after restart", done_n - d0, 1);
  endtask

  task automatic t_latched();
    int b0 = byte_n, w0;
    watch_addr = 32'h1E0;
    w0 = watch_n;
    mk_desc(32'h1C0, OWN | LAST, 32'd40, 32'h800);
    pulse_poll();
    repeat (6) @(negedge clk);
    chk("R8", "walk busy at second poll", mem_req | tx_valid, 1);
    pulse_poll();
    wait_idle();
    chk("R8", "bytes of the walk", byte_n - b0, 40);
    chk("R8", "end descriptor read by both walks", watch_n - w0, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int k = 0; k < 512; k++)
      host_wr(32'h800 + 4 * k, {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)});
    @(negedge clk); base_we = 1'b1; base_addr = 32'h100;
    @(negedge clk); base_we = 1'b0;
    t_single();
    t_multi();
    t_wrap();
    t_reject();
    t_limit();
    t_latched();
    finish_run();
  end
endmodule